// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block is the per-hart interrupt source that a core's machine mode uses for its timer and for inter-processor software interrupts. It keeps three pieces of state: a single software-pending bit, a 64-bit timer compare value and a 64-bit time counter that advances by one on every pulse of a tick input. The two pending bits are driven straight out to the core as level interrupt requests.

Software reaches the state through a simple request port. Each request carries a read/write flag, an address, an access size in bytes and write data. The block subtracts its configured base address, checks the result against three fixed register offsets and the allowed sizes, and answers one cycle later with read data or with a typed fault. A load fault and a store fault are kept apart so that the core can raise the matching exception. Each register is reached by one exact, aligned access only; any partial, misaligned or unmapped access faults and leaves all state unchanged.

The timer-pending output is never held as a sticky flag. After every tick and every accepted store it is computed again as "compare is unsigned at or below time". Writing a larger compare value therefore withdraws a pending timer interrupt on the same edge that accepts the write.

Top module: `hart_timer_irq`

## Requirements
- R1: Addresses are decoded as (address minus BASE_ADDR). The software-pending register is at offset 0x0000, timer compare is at 0x4000 and time is at 0xBFF8. Any other offset matches nothing.
- R2: The software-pending register accepts loads and stores only with an access size of 4 or 8 bytes. Sizes 1 and 2 fault.
- R3: Timer compare accepts loads and stores only with a size of 8 bytes. Time accepts only 8-byte loads, and any store to time faults.
- R4: An accepted store to the software-pending register sets sw_irq to bit 0 of the write data and ignores all other data bits.
- R5: An accepted load of the software-pending register returns the pending bit in bit 0 and zeros in bits 63:1.
- R6: A load that matches no register or uses a disallowed size sets rsp_load_fault, clears rsp_store_fault, returns zero read data and changes no state.
- R7: A store that matches no register or uses a disallowed size sets rsp_store_fault, clears rsp_load_fault and changes no state.
- R8: On the edge that takes a tick or an accepted store, timer_irq becomes 1 exactly when the compare value after that edge is unsigned less than or equal to the time value after that edge. Otherwise timer_irq holds its value.
- R9: Each cycle with tick high increments time by exactly one, and time holds its value in cycles without tick. An accepted store to compare zero-extends the write data to 64 bits before storing it.
- R10: Synchronous active-high reset clears sw_irq, timer_irq and time, sets compare to all ones, and clears the response outputs.
- R11: Each request cycle yields rsp_valid on the following cycle together with that request's read data and fault flags. A cycle without a request gives rsp_valid low and both fault flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base pulse; each high cycle advances time by one |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W (32) | Byte address of the request |
| req_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| req_wdata | input | 64 | Store data, least significant byte first |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 64 | Load data; zero for stores and faults |
| rsp_load_fault | output | 1 | The previous load was refused |
| rsp_store_fault | output | 1 | The previous store was refused |
| sw_irq | output | 1 | Machine software interrupt pending |
| timer_irq | output | 1 | Machine timer interrupt pending |

## Verification
Each result lands on the first clock edge after its stimulus. The response, the new software-pending bit, the new compare value, the incremented time and the recomputed timer-pending bit all become visible together, one edge after the request or tick is driven. The bench drives each request and tick on a falling edge. It updates a reference model of the registers at that time and compares every output on the next falling edge, which is exactly one rising edge later. Loads of time and compare return the value held before that edge, so the model reads its state before it applies the cycle's store and tick.

// File: rtl/hti_pkg.sv
package hti_pkg;

  localparam int unsigned DATA_W   = 64;
  localparam int unsigned OFF_W    = 16;

  localparam logic [OFF_W-1:0] OFF_SWI  = 16'h0000;
  localparam logic [OFF_W-1:0] OFF_CMP  = 16'h4000;
  localparam logic [OFF_W-1:0] OFF_TIME = 16'hBFF8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SWI  = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_TIME = 2'd3
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     legal;
  } decode_t;

endpackage

// File: rtl/hti_decode.sv
module hti_decode #(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0200_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  input  logic              write,
  output hti_pkg::decode_t  dec
);
  import hti_pkg::*;

  localparam logic [ADDR_W-1:0] SWI_A  = ADDR_W'(OFF_SWI);
  localparam logic [ADDR_W-1:0] CMP_A  = ADDR_W'(OFF_CMP);
  localparam logic [ADDR_W-1:0] TIME_A = ADDR_W'(OFF_TIME);

  logic [ADDR_W-1:0] rel;
  logic              size4, size8;

  always_comb begin
    rel   = addr - BASE_ADDR;
    size4 = (size == 4'd4);
    size8 = (size == 4'd8);
    dec.sel   = SEL_NONE;
    dec.legal = 1'b0;
    if (rel == SWI_A) begin
      dec.sel   = SEL_SWI;
      dec.legal = size4 | size8;
    end else if (rel == CMP_A) begin
      dec.sel   = SEL_CMP;
      dec.legal = size8;
    end else if (rel == TIME_A) begin
      dec.sel   = SEL_TIME;
      dec.legal = size8 & ~write;
    end
  end

endmodule

// File: rtl/hti_timebase.sv
module hti_timebase #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             store_done,
  output logic [CNT_W-1:0] time_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             tip_q
);

  logic [CNT_W-1:0] time_n, cmp_n;
  logic             recompute;

  always_comb begin
    time_n    = tick ? time_q + CNT_W'(1) : time_q;
    cmp_n     = cmp_we ? cmp_wdata : cmp_q;
    recompute = tick | store_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '0;
      cmp_q  <= '1;
      tip_q  <= 1'b0;
    end else begin
      time_q <= time_n;
      cmp_q  <= cmp_n;
      if (recompute) tip_q <= (cmp_n <= time_n);
    end
  end

  // R9: tick advances time by one
  a_r9_tick_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> time_q == $past(time_q) + CNT_W'(1));
  // R9: time holds without tick
  a_r9_time_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(time_q));
  // R8: pending bit holds when nothing triggers a recompute
  a_r8_tip_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !store_done) |=> $stable(tip_q));
  // R8: after a tick, pending agrees with the stored compare and time
  a_r8_tip_after_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> tip_q == (cmp_q <= time_q));

endmodule

// File: rtl/hart_timer_irq.sv
module hart_timer_irq #(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_load_fault,
  output logic              rsp_store_fault,
  output logic              sw_irq,
  output logic              timer_irq
);
  import hti_pkg::*;

  decode_t           dec;
  logic              acc_ok, st_ok, ld_ok;
  logic              cmp_we;
  logic [DATA_W-1:0] time_v, cmp_v, rd_mux;

  hti_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr (req_addr),
    .size (req_size),
    .write(req_write),
    .dec  (dec)
  );

  always_comb begin
    acc_ok = req_valid & dec.legal;
    st_ok  = acc_ok & req_write;
    ld_ok  = acc_ok & ~req_write;
    cmp_we = st_ok & (dec.sel == SEL_CMP);
    rd_mux = '0;
    if (ld_ok) begin
      case (dec.sel)
        SEL_SWI:  rd_mux = {{(DATA_W-1){1'b0}}, sw_irq};
        SEL_CMP:  rd_mux = cmp_v;
        SEL_TIME: rd_mux = time_v;
        default:  rd_mux = '0;
      endcase
    end
  end

  hti_timebase #(.CNT_W(DATA_W)) u_tb (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmp_we    (cmp_we),
    .cmp_wdata (req_wdata),
    .store_done(st_ok),
    .time_q    (time_v),
    .cmp_q     (cmp_v),
    .tip_q     (timer_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_irq          <= 1'b0;
      rsp_valid       <= 1'b0;
      rsp_rdata       <= '0;
      rsp_load_fault  <= 1'b0;
      rsp_store_fault <= 1'b0;
    end else begin
      if (st_ok && dec.sel == SEL_SWI) sw_irq <= req_wdata[0];
      rsp_valid       <= req_valid;
      rsp_rdata       <= rd_mux;
      rsp_load_fault  <= req_valid & ~req_write & ~dec.legal;
      rsp_store_fault <= req_valid & req_write & ~dec.legal;
    end
  end

  // R11: every request is answered on the next cycle
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R11: no fault flags without a response
  a_r11_no_stray_fault: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_load_fault || rsp_store_fault));
  // R6 / R7: at most one fault kind at a time
  a_r7_fault_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_load_fault, rsp_store_fault}));
  // R4: software-pending bit only moves on a store
  a_r4_swi_only_store: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(sw_irq));
  // R6: faulted loads return zero data
  a_r6_fault_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_load_fault |-> rsp_rdata == '0);

endmodule

// File: tb/sim_hart_timer_irq.sv
module sim_hart_timer_irq;

  localparam logic [31:0] BASE = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_load_fault, rsp_store_fault, sw_irq, timer_irq;
  logic [63:0] rsp_rdata;

  int errors = 0;
  int checks = 0;

  logic        m_sip, m_tip;
  logic [63:0] m_cmp, m_time;

  always #5 clk = ~clk;

  hart_timer_irq #(.ADDR_W(32), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst(rst), .tick(tick),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_load_fault(rsp_load_fault), .rsp_store_fault(rsp_store_fault),
    .sw_irq(sw_irq), .timer_irq(timer_irq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, check one rising edge later.
  task automatic op(input string tag, input logic v, input logic wr,
                    input logic [31:0] off, input logic [3:0] sz,
                    input logic [63:0] wd, input logic tk);
    logic [31:0] rel;
    logic        ok, e_lf, e_sf;
    logic [63:0] e_rd;
    rel = off;
    ok = 1'b0; e_rd = '0;
    if (rel == 32'h0) ok = (sz == 4 || sz == 8);
    else if (rel == 32'h4000) ok = (sz == 8);
    else if (rel == 32'hBFF8) ok = (sz == 8) && !wr;
    e_lf = v && !wr && !ok;
    e_sf = v && wr && !ok;
    if (v && !wr && ok)
      e_rd = (rel == 32'h0) ? {63'd0, m_sip} : (rel == 32'h4000) ? m_cmp : m_time;
    if (v && wr && ok) begin
      if (rel == 32'h0) m_sip = wd[0];
      else m_cmp = wd;
    end
    if (tk) m_time = m_time + 64'd1;
    if (tk || (v && wr && ok)) m_tip = (m_cmp <= m_time);
    req_valid = v; req_write = wr; req_addr = BASE + off;
    req_size = sz; req_wdata = wd; tick = tk;
    @(negedge clk);
    req_valid = 1'b0; tick = 1'b0;
    chk(tag, "rsp_valid", {63'd0, rsp_valid}, {63'd0, v});
    chk(tag, "rdata", rsp_rdata, e_rd);
    chk(tag, "load_fault", {63'd0, rsp_load_fault}, {63'd0, e_lf});
    chk(tag, "store_fault", {63'd0, rsp_store_fault}, {63'd0, e_sf});
    chk(tag, "sw_irq", {63'd0, sw_irq}, {63'd0, m_sip});
    chk(tag, "timer_irq", {63'd0, timer_irq}, {63'd0, m_tip});
  endtask

  task automatic rd_abs(input string tag, input logic [31:0] a, input logic [63:0] exp_rd,
                        input logic exp_fault);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = 4'd8;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "abs rdata", rsp_rdata, exp_rd);
    chk(tag, "abs load_fault", {63'd0, rsp_load_fault}, {63'd0, exp_fault});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_sip = 0; m_tip = 0; m_cmp = '1; m_time = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10", "sw_irq", {63'd0, sw_irq}, 64'd0);
    chk("R10", "timer_irq", {63'd0, timer_irq}, 64'd0);
    chk("R10", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
    op("R10", 1, 0, 32'h4000, 8, 0, 0);          // compare reads all ones
    op("R10", 1, 0, 32'hBFF8, 8, 0, 0);          // time reads zero
    // R1: base is subtracted; raw offsets and neighbours fault
    rd_abs("R1", 32'h0000_BFF8, 64'd0, 1'b1);
    rd_abs("R1", BASE + 32'h4000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    op("R1", 1, 0, 32'h4008, 8, 0, 0);
    op("R1", 1, 1, 32'hBFF0, 8, 64'h5, 0);
    // R4: only bit 0 of write data matters
    op("R4", 1, 1, 32'h0, 4, 64'hFFFF_FFFF_FFFF_FFFE, 0);
    op("R4", 1, 1, 32'h0, 8, 64'h1, 0);
    // R2: sizes 1 and 2 refused, state kept (R7)
    op("R2", 1, 1, 32'h0, 2, 64'h0, 0);
    op("R2", 1, 1, 32'h0, 1, 64'h0, 0);
    op("R7", 1, 1, 32'h4, 4, 64'h0, 0);
    // R5: zero-extended read of pending bit
    op("R5", 1, 0, 32'h0, 4, 0, 0);
    op("R5", 1, 0, 32'h0, 8, 0, 0);
    // R6: bad-width and unmapped loads
    op("R6", 1, 0, 32'h0, 1, 0, 0);
    op("R6", 1, 0, 32'hBFF8, 4, 0, 0);
    op("R6", 1, 0, 32'h2000, 8, 0, 0);
    // R3: compare needs 8 bytes; time refuses stores
    op("R3", 1, 1, 32'h4000, 4, 64'h3, 0);
    op("R3", 1, 1, 32'hBFF8, 8, 64'h99, 0);
    op("R3", 1, 0, 32'h4000, 8, 0, 0);
    // R8 / R9: compare at 4, tick up through the match
    op("R9", 1, 1, 32'h4000, 8, 64'h4, 0);
    for (int i = 0; i < 6; i++) op("R8", 0, 0, 0, 0, 0, 1);
    op("R9", 1, 0, 32'hBFF8, 8, 0, 0);
    // R8: raising compare withdraws pending on the store edge
    op("R8", 1, 1, 32'h4000, 8, 64'h100, 0);
    op("R8", 1, 1, 32'h4000, 8, 64'h2, 1);       // store and tick together
    op("R11", 0, 0, 0, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] off;
      logic [3:0]  sz;
      logic [63:0] wd;
      case ($urandom % 6)
        0: off = 32'h0;
        1, 2: off = 32'h4000;
        3: off = 32'hBFF8;
        4: off = 32'h4;
        default: off = $urandom & 32'hFFFF;
      endcase
      case ($urandom % 5)
        0: sz = 4'd1;
        1: sz = 4'd2;
        2: sz = 4'd4;
        default: sz = 4'd8;
      endcase
      wd = (off == 32'h0) ? {$urandom, $urandom}
                          : m_time + 64'($urandom % 40) - 64'd10;
      op("R8", ($urandom % 4) != 0, $urandom % 2, off, sz, wd, ($urandom % 2) == 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule